// File: doc/BRIEF.md
# Coprocessor Instruction Decode and Execute Unit

This unit accepts at most one coprocessor instruction per clock cycle. It checks the instruction against one of four formats and carries out the instruction on the register spaces it can reach. The instruction arrives in a 64-bit word and is aligned to the top of that word. A 2-bit code gives the length of the instruction: 0 means 16 bits, 1 means 32 bits, 2 means 48 bits and 3 means 64 bits. Field positions are counted from the most significant end, so position 0 is `in_word[63]`. The top four positions hold the major opcode. The bits of the word that lie below the instruction's length carry no meaning.

The unit holds two register files of its own:
- a coprocessor file of 64-bit entries;
- a control file of 32-bit entries.

The 32-bit core register file lives outside the block. The unit reaches it through one combinational read port and through one write strobe, which carries its index and data in the same cycle as the instruction. Moves in both directions are supported between the coprocessor file and core registers, either whole-word or by half. One form rewrites only the upper half of a coprocessor register from a core register. Moves between core registers and control registers are also supported.

A 48-bit form raises an exception request when its first immediate is zero. Every malformed encoding raises a one-cycle illegal flag and has no effect on state. A run-alone indicator reports the marker that the longer formats carry, so that surrounding issue logic can use it.

Top module: `cpx_exec_unit`

## Requirements
- R1: A synchronous reset sets every coprocessor entry and every control entry to zero.
- R2: 16-bit major opcode 1 with positions 9-10 zero copies coprocessor register m into coprocessor register n. Register n is at positions 4-8 and register m is at positions 11-15.
- R3: 16-bit major opcode 2 with positions 9-11 zero writes core register r into coprocessor register n, zero-extended. Major opcode 3 with the same zero positions writes the low 32 bits of coprocessor register n to core register r. Register r is at positions 12-15.
- R4: A 16-bit word that is all zero is a legal no-op. For the 16-, 32- and 48-bit lengths, the word bits below the instruction are ignored.
- R5: A legal 32-bit instruction has major opcode F, zero at positions 4-11, 0111 at positions 12-15 and zero at positions 16-20. A 3-bit selector at positions 21-23 picks the operation. Selector 0 is legal only when positions 24-31 are zero. Selector 1 accepts any value at positions 24-31. Neither selector changes any register.
- R6: A legal 48-bit instruction has major opcode 4 or 5 and zero at positions 4-15. Opcode 4 raises exc_req in the same cycle when positions 16-31 are zero. Otherwise neither opcode has any visible effect.
- R7: A legal 64-bit instruction has major opcode F, zero at positions 4-11, 0111 at positions 12-15 and zero at positions 16-23. The selector is at positions 24-31. Selectors 0 and 7 do nothing. Selector 1 writes core register r into coprocessor register n, zero-extended. Selector 2 writes the low half of coprocessor register n to core register r. For selectors 1 to 4, register n is at positions 32-36 and register r is at positions 37-40, and positions 41-63 are ignored.
- R8: 64-bit selector 3 sets the upper half of coprocessor register n to core register r and keeps its lower half. Selector 4 writes the upper half of coprocessor register n to core register r.
- R9: 64-bit selector 5 copies core register r into control register n. Selector 6 copies control register n into core register r. Here n is at positions 32-35, r is at positions 36-39, and positions 40-63 are ignored.
- R10: Any other encoding raises illegal in the same cycle. This includes a major opcode that does not match the length code (0:16, 1:32, 2:48, 3:64), a nonzero reserved field, and an unknown selector. An illegal instruction changes no register, writes no core register and raises no exception.
- R11: illegal, exc_req, run_alone and the core write strobe, index and data all reflect the instruction in the cycle it is presented. A coprocessor or control write is readable from the following cycle on.
- R12: run_alone is high exactly when a valid 32-bit or 64-bit instruction carries 0111 at positions 12-15. This holds even when the instruction is otherwise illegal.
- R13: While in_valid is low, every output flag and the core write strobe stay low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is present this cycle |
| in_len | input | 2 | Length code: 0=16, 1=32, 2=48, 3=64 bits |
| in_word | input | 64 | Instruction, aligned to the most significant end |
| core_rd_idx | output | 4 | Core register read index |
| core_rd_data | input | 32 | Core register read data, combinational |
| core_wr_en | output | 1 | Core register write strobe |
| core_wr_idx | output | 4 | Core register write index |
| core_wr_data | output | 32 | Core register write data |
| illegal | output | 1 | Malformed instruction this cycle |
| exc_req | output | 1 | Exception request this cycle |
| run_alone | output | 1 | Run-alone marker present |

## Verification
Three results come in the same cycle as the instruction, with no register in their path: the flags, the core write strobe and its index and data. Coprocessor and control contents show only after the next rising edge. They are observed through a later read-back instruction that moves them onto the core write port.

The bench drives each instruction at the falling edge and compares the combinational results two nanoseconds later. It updates its own model of all three register files only after the following rising edge, so every read-back compares against state one edge older. Random legal encodings, single-bit corruptions and raw random words are mixed with directed sequences for reset, splicing, exception and illegal-blocking cases.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   localparam int CPX_WORD_W     = 64;
   localparam int CPX_CP_FLD_W   = 5;
   localparam int CPX_CORE_FLD_W = 4;
   localparam int CPX_CTL_FLD_W  = 4;

   localparam logic [1:0] CPX_LEN16 = 2'd0;
   localparam logic [1:0] CPX_LEN32 = 2'd1;
   localparam logic [1:0] CPX_LEN48 = 2'd2;
   localparam logic [1:0] CPX_LEN64 = 2'd3;

   localparam logic [3:0] CPX_ALONE_MARK = 4'b0111;
   localparam logic [3:0] CPX_OP_EXT     = 4'hF;
   localparam logic [3:0] CPX_OP_MOVE    = 4'h1;
   localparam logic [3:0] CPX_OP_LOAD    = 4'h2;
   localparam logic [3:0] CPX_OP_STORE   = 4'h3;
   localparam logic [3:0] CPX_OP_TRAP    = 4'h4;
   localparam logic [3:0] CPX_OP_SUM     = 4'h5;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_CP_COPY,
      ACT_CP_LOAD,
      ACT_CP_SPLICE_HI,
      ACT_CORE_CP_LO,
      ACT_CORE_CP_HI,
      ACT_CTL_LOAD,
      ACT_CORE_CTL
   } cpx_act_e;

   typedef struct packed {
      logic                      legal;
      logic                      illegal;
      logic                      exc;
      logic                      run_alone;
      cpx_act_e                  act;
      logic [CPX_CP_FLD_W-1:0]   cp_n;
      logic [CPX_CP_FLD_W-1:0]   cp_m;
      logic [CPX_CORE_FLD_W-1:0] core_r;
      logic [CPX_CTL_FLD_W-1:0]  ctl_n;
   } cpx_dec_t;

endpackage

// File: rtl/cpx_regbank.sv
module cpx_regbank #(
   parameter int DEPTH    = 32,
   parameter int WIDTH    = 64,
   parameter int RD_PORTS = 1,
   parameter int IW       = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [IW-1:0]                  wr_idx,
   input  logic [WIDTH-1:0]               wr_data,
   input  logic [RD_PORTS-1:0][IW-1:0]    rd_idx,
   output logic [RD_PORTS-1:0][WIDTH-1:0] rd_data
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cpx_regbank: DEPTH must be a power of two of at least 2");
   end
   if (RD_PORTS < 1) begin : g_bad_ports
      $error("cpx_regbank: RD_PORTS must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_idx[p]];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> mem[i] == '0);
      a_r11_entry_written: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_idx == IW'(i)) |=> mem[i] == $past(wr_data));
      a_r10_entry_held: assert property (@(posedge clk) disable iff (rst)
         !(wr_en && wr_idx == IW'(i)) |=> $stable(mem[i]));
   end

endmodule

// File: rtl/cpx_decode.sv
module cpx_decode
   import cpx_pkg::*;
(
   input  logic                  in_valid,
   input  logic [1:0]            in_len,
   input  logic [CPX_WORD_W-1:0] iw,
   output cpx_dec_t              dec
);

   logic [3:0] op;
   logic [7:0] sel64;
   logic [2:0] sel32;
   logic       marker;
   logic       ok;
   logic       trap;
   logic       ra;
   cpx_act_e   act;
   logic       ign_unused_tail;

   assign op     = iw[63:60];
   assign sel64  = iw[39:32];
   assign sel32  = iw[42:40];
   assign marker = (iw[51:48] == CPX_ALONE_MARK);
   assign ign_unused_tail = ^iw[22:0];

   always_comb begin
      ok   = 1'b0;
      trap = 1'b0;
      ra   = 1'b0;
      act  = ACT_NONE;
      unique case (in_len)
         CPX_LEN16: begin
            if (iw[63:48] == '0) begin
               ok = 1'b1;
            end else begin
               case (op)
                  CPX_OP_MOVE:  if (iw[54:53] == '0) begin ok = 1'b1; act = ACT_CP_COPY;    end
                  CPX_OP_LOAD:  if (iw[54:52] == '0) begin ok = 1'b1; act = ACT_CP_LOAD;    end
                  CPX_OP_STORE: if (iw[54:52] == '0) begin ok = 1'b1; act = ACT_CORE_CP_LO; end
                  default: ;
               endcase
            end
         end
         CPX_LEN32: begin
            ra = marker;
            if (op == CPX_OP_EXT && iw[59:52] == '0 && marker && iw[47:43] == '0) begin
               if (sel32 == 3'd1) ok = 1'b1;
               else if (sel32 == 3'd0 && iw[39:32] == '0) ok = 1'b1;
            end
         end
         CPX_LEN48: begin
            if (iw[59:48] == '0) begin
               if (op == CPX_OP_TRAP) begin
                  ok   = 1'b1;
                  trap = (iw[47:32] == '0);
               end else if (op == CPX_OP_SUM) begin
                  ok = 1'b1;
               end
            end
         end
         default: begin
            ra = marker;
            if (op == CPX_OP_EXT && iw[59:52] == '0 && marker && iw[47:40] == '0) begin
               case (sel64)
                  8'd0, 8'd7: ok = 1'b1;
                  8'd1: begin ok = 1'b1; act = ACT_CP_LOAD;      end
                  8'd2: begin ok = 1'b1; act = ACT_CORE_CP_LO;   end
                  8'd3: begin ok = 1'b1; act = ACT_CP_SPLICE_HI; end
                  8'd4: begin ok = 1'b1; act = ACT_CORE_CP_HI;   end
                  8'd5: begin ok = 1'b1; act = ACT_CTL_LOAD;     end
                  8'd6: begin ok = 1'b1; act = ACT_CORE_CTL;     end
                  default: ;
               endcase
            end
         end
      endcase
   end

   always_comb begin
      dec           = '0;
      dec.legal     = in_valid && ok;
      dec.illegal   = in_valid && !ok;
      dec.exc       = in_valid && ok && trap;
      dec.run_alone = in_valid && ra;
      dec.act       = (in_valid && ok) ? act : ACT_NONE;
      dec.ctl_n     = iw[31:28];
      if (in_len == CPX_LEN64) begin
         dec.cp_n   = iw[31:27];
         dec.cp_m   = iw[31:27];
         dec.core_r = (sel64 == 8'd5 || sel64 == 8'd6) ? iw[27:24] : iw[26:23];
      end else begin
         dec.cp_n   = iw[59:55];
         dec.cp_m   = iw[52:48];
         dec.core_r = iw[51:48];
      end
   end

endmodule

// File: rtl/cpx_exec_unit.sv
module cpx_exec_unit
   import cpx_pkg::*;
#(
   parameter int CORE_W     = 32,
   parameter int CP_DEPTH   = 32,
   parameter int CTL_DEPTH  = 64,
   parameter int CORE_DEPTH = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [1:0]                    in_len,
   input  logic [CPX_WORD_W-1:0]         in_word,
   output logic [$clog2(CORE_DEPTH)-1:0] core_rd_idx,
   input  logic [CORE_W-1:0]             core_rd_data,
   output logic                          core_wr_en,
   output logic [$clog2(CORE_DEPTH)-1:0] core_wr_idx,
   output logic [CORE_W-1:0]             core_wr_data,
   output logic                          illegal,
   output logic                          exc_req,
   output logic                          run_alone
);

   localparam int CP_W   = 2 * CORE_W;
   localparam int CP_IW  = $clog2(CP_DEPTH);
   localparam int CTL_IW = $clog2(CTL_DEPTH);

   if (CP_DEPTH != (1 << CPX_CP_FLD_W)) begin : g_bad_cp
      $error("cpx_exec_unit: CP_DEPTH must match the 5-bit register field");
   end
   if (CORE_DEPTH != (1 << CPX_CORE_FLD_W)) begin : g_bad_core
      $error("cpx_exec_unit: CORE_DEPTH must match the 4-bit register field");
   end
   if (CTL_DEPTH < (1 << CPX_CTL_FLD_W) || (CTL_DEPTH & (CTL_DEPTH - 1)) != 0) begin : g_bad_ctl
      $error("cpx_exec_unit: CTL_DEPTH must be a power of two of at least 16");
   end
   if (CORE_W < 1) begin : g_bad_w
      $error("cpx_exec_unit: CORE_W must be positive");
   end

   cpx_dec_t dec;

   cpx_decode u_dec (
      .in_valid (in_valid),
      .in_len   (in_len),
      .iw       (in_word),
      .dec      (dec)
   );

   logic                      cp_we;
   logic [CP_W-1:0]           cp_wdata;
   logic [1:0][CP_IW-1:0]     cp_rd_idx;
   logic [1:0][CP_W-1:0]      cp_rd;
   logic                      ctl_we;
   logic [CTL_IW-1:0]         ctl_idx;
   logic [0:0][CTL_IW-1:0]    ctl_rd_idx;
   logic [0:0][CORE_W-1:0]    ctl_rd;

   assign cp_rd_idx[0] = dec.cp_n;
   assign cp_rd_idx[1] = dec.cp_m;

   if (CTL_IW > CPX_CTL_FLD_W) begin : g_ctl_pad
      assign ctl_idx = {{(CTL_IW - CPX_CTL_FLD_W){1'b0}}, dec.ctl_n};
   end else begin : g_ctl_exact
      assign ctl_idx = dec.ctl_n;
   end
   assign ctl_rd_idx[0] = ctl_idx;

   always_comb begin
      cp_we    = 1'b0;
      cp_wdata = cp_rd[1];
      case (dec.act)
         ACT_CP_COPY:      begin cp_we = 1'b1; cp_wdata = cp_rd[1]; end
         ACT_CP_LOAD:      begin cp_we = 1'b1; cp_wdata = {{CORE_W{1'b0}}, core_rd_data}; end
         ACT_CP_SPLICE_HI: begin cp_we = 1'b1; cp_wdata = {core_rd_data, cp_rd[0][CORE_W-1:0]}; end
         default: ;
      endcase
   end

   assign ctl_we = (dec.act == ACT_CTL_LOAD);

   always_comb begin
      core_wr_en   = 1'b0;
      core_wr_data = cp_rd[0][CORE_W-1:0];
      case (dec.act)
         ACT_CORE_CP_LO: begin core_wr_en = 1'b1; core_wr_data = cp_rd[0][CORE_W-1:0]; end
         ACT_CORE_CP_HI: begin core_wr_en = 1'b1; core_wr_data = cp_rd[0][CP_W-1:CORE_W]; end
         ACT_CORE_CTL:   begin core_wr_en = 1'b1; core_wr_data = ctl_rd[0]; end
         default: ;
      endcase
   end

   assign core_rd_idx = dec.core_r;
   assign core_wr_idx = dec.core_r;
   assign illegal     = dec.illegal;
   assign exc_req     = dec.exc;
   assign run_alone   = dec.run_alone;

   cpx_regbank #(.DEPTH(CP_DEPTH), .WIDTH(CP_W), .RD_PORTS(2)) u_cp_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cp_we),
      .wr_idx  (dec.cp_n),
      .wr_data (cp_wdata),
      .rd_idx  (cp_rd_idx),
      .rd_data (cp_rd)
   );

   cpx_regbank #(.DEPTH(CTL_DEPTH), .WIDTH(CORE_W), .RD_PORTS(1)) u_ctl_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (ctl_we),
      .wr_idx  (ctl_idx),
      .wr_data (core_rd_data),
      .rd_idx  (ctl_rd_idx),
      .rd_data (ctl_rd)
   );

   a_r10_illegal_blocks_writes: assert property (@(posedge clk) disable iff (rst)
      illegal |-> !(core_wr_en || cp_we || ctl_we || exc_req));
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> !(illegal || exc_req || run_alone || core_wr_en || cp_we || ctl_we));
   a_r6_exc_from_48: assert property (@(posedge clk) disable iff (rst)
      exc_req |-> (in_len == CPX_LEN48 && !illegal));
   a_r10_one_effect: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cp_we, ctl_we, core_wr_en, exc_req}));
   a_r12_alone_long_only: assert property (@(posedge clk) disable iff (rst)
      run_alone |-> (in_len == CPX_LEN32 || in_len == CPX_LEN64));

endmodule

// File: tb/cpx_exec_unit_bench.sv
module cpx_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_len = 2'd0;
   logic [63:0] in_word = '0;
   logic [3:0]  core_rd_idx;
   logic [31:0] core_rd_data;
   logic        core_wr_en;
   logic [3:0]  core_wr_idx;
   logic [31:0] core_wr_data;
   logic        illegal;
   logic        exc_req;
   logic        run_alone;

   always #5 clk = ~clk;

   logic [63:0] m_cp  [32];
   logic [31:0] m_ctl [64];
   logic [31:0] m_core[16];

   assign core_rd_data = m_core[core_rd_idx];

   cpx_exec_unit u_cpx_exec_unit (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_len       (in_len),
      .in_word      (in_word),
      .core_rd_idx  (core_rd_idx),
      .core_rd_data (core_rd_data),
      .core_wr_en   (core_wr_en),
      .core_wr_idx  (core_wr_idx),
      .core_wr_data (core_wr_data),
      .illegal      (illegal),
      .exc_req      (exc_req),
      .run_alone    (run_alone)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic        e_ill, e_exc, e_ra, e_cwe, e_pwe, e_kwe;
   logic [3:0]  e_cidx;
   logic [31:0] e_cdat, e_kdat;
   logic [4:0]  e_pidx;
   logic [63:0] e_pdat;
   logic [5:0]  e_kidx;
   string       e_tag;

   function automatic logic [63:0] fld(input logic [63:0] w, input int pos, input int wd);
      return (w >> (64 - pos - wd)) & ((64'd1 << wd) - 64'd1);
   endfunction

   function automatic logic [63:0] enc64(input logic [7:0] sel, input logic [31:0] lo);
      return {4'hF, 8'h00, 4'h7, 8'h00, sel, lo};
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic predict(input logic v, input logic [1:0] ln, input logic [63:0] w);
      logic [3:0] op;
      logic [7:0] sel;
      logic [4:0] n;
      logic [3:0] r;
      logic       ok;
      e_ill = 0; e_exc = 0; e_ra = 0; e_cwe = 0; e_pwe = 0; e_kwe = 0;
      e_cidx = 0; e_cdat = 0; e_pidx = 0; e_pdat = 0; e_kidx = 0; e_kdat = 0;
      e_tag = "R13";
      if (!v) return;
      op = 4'(fld(w, 0, 4));
      ok = 0;
      if (ln == 2'd0) begin
         n = 5'(fld(w, 4, 5)); r = 4'(fld(w, 12, 4)); e_tag = "R4";
         if (fld(w, 0, 16) == 0) ok = 1;
         else if (op == 1 && fld(w, 9, 2) == 0) begin
            ok = 1; e_tag = "R2"; e_pwe = 1; e_pidx = n; e_pdat = m_cp[fld(w, 11, 5)];
         end else if (op == 2 && fld(w, 9, 3) == 0) begin
            ok = 1; e_tag = "R3"; e_pwe = 1; e_pidx = n; e_pdat = {32'd0, m_core[r]};
         end else if (op == 3 && fld(w, 9, 3) == 0) begin
            ok = 1; e_tag = "R3"; e_cwe = 1; e_cidx = r; e_cdat = m_cp[n][31:0];
         end
      end else if (ln == 2'd1) begin
         e_tag = "R5"; e_ra = (fld(w, 12, 4) == 7);
         sel = 8'(fld(w, 21, 3));
         if (op == 15 && fld(w, 4, 8) == 0 && e_ra && fld(w, 16, 5) == 0 &&
             (sel == 1 || (sel == 0 && fld(w, 24, 8) == 0))) ok = 1;
      end else if (ln == 2'd2) begin
         e_tag = "R6";
         if ((op == 4 || op == 5) && fld(w, 4, 12) == 0) begin
            ok = 1; e_exc = (op == 4) && (fld(w, 16, 16) == 0);
         end
      end else begin
         e_tag = "R7"; e_ra = (fld(w, 12, 4) == 7);
         sel = 8'(fld(w, 24, 8)); n = 5'(fld(w, 32, 5)); r = 4'(fld(w, 37, 4));
         if (op == 15 && fld(w, 4, 8) == 0 && e_ra && fld(w, 16, 8) == 0) begin
            case (sel)
               8'd0, 8'd7: ok = 1;
               8'd1: begin ok = 1; e_pwe = 1; e_pidx = n; e_pdat = {32'd0, m_core[r]}; end
               8'd2: begin ok = 1; e_cwe = 1; e_cidx = r; e_cdat = m_cp[n][31:0]; end
               8'd3: begin ok = 1; e_tag = "R8"; e_pwe = 1; e_pidx = n; e_pdat = {m_core[r], m_cp[n][31:0]}; end
               8'd4: begin ok = 1; e_tag = "R8"; e_cwe = 1; e_cidx = r; e_cdat = m_cp[n][63:32]; end
               8'd5: begin ok = 1; e_tag = "R9"; e_kwe = 1; e_kidx = 6'(fld(w, 32, 4)); e_kdat = m_core[fld(w, 36, 4)]; end
               8'd6: begin ok = 1; e_tag = "R9"; e_cwe = 1; e_cidx = 4'(fld(w, 36, 4)); e_cdat = m_ctl[fld(w, 32, 4)]; end
               default: ok = 0;
            endcase
         end
      end
      if (!ok) begin
         e_ill = 1; e_exc = 0; e_cwe = 0; e_pwe = 0; e_kwe = 0; e_tag = "R10";
      end
   endtask

   task automatic run_instr(input logic v, input logic [1:0] ln, input logic [63:0] w, input string force_tag);
      string t;
      @(negedge clk);
      in_valid = v; in_len = ln; in_word = w;
      #2;
      predict(v, ln, w);
      t = (force_tag != "") ? force_tag : e_tag;
      check(t, "illegal", 64'(illegal), 64'(e_ill));
      check(t, "exc_req", 64'(exc_req), 64'(e_exc));
      check("R12", "run_alone", 64'(run_alone), 64'(e_ra));
      check(t, "core_wr_en", 64'(core_wr_en), 64'(e_cwe));
      if (e_cwe) begin
         check(t, "core_wr_idx", 64'(core_wr_idx), 64'(e_cidx));
         check(t, "core_wr_data", 64'(core_wr_data), 64'(e_cdat));
      end
      @(posedge clk);
      #1;
      if (e_pwe) m_cp[e_pidx] = e_pdat;
      if (e_kwe) m_ctl[e_kidx] = e_kdat;
      if (e_cwe) m_core[e_cidx] = e_cdat;
   endtask

   function automatic logic [63:0] rd_lo(input logic [4:0] n, input logic [3:0] r);
      return {4'h3, n, 3'b000, r, 48'h0};
   endfunction

   function automatic logic [63:0] rd_hi(input logic [4:0] n, input logic [3:0] r);
      return enc64(8'd4, {n, r, 23'd0});
   endfunction

   function automatic logic [63:0] rd_ctl(input logic [3:0] cn, input logic [3:0] r);
      return enc64(8'd6, {cn, r, 24'd0});
   endfunction

   task automatic gen_random(output logic [1:0] ln, output logic [63:0] w);
      int k;
      int bits;
      k = int'($urandom % 10);
      w = {$urandom, $urandom};
      case (k)
         0: begin ln = 2'd0; w = {4'h1, 5'($urandom), 2'b00, 5'($urandom), w[47:0]}; end
         1: begin ln = 2'd0; w = {4'h2, 5'($urandom), 3'b000, 4'($urandom), w[47:0]}; end
         2: begin ln = 2'd0; w = {4'h3, 5'($urandom), 3'b000, 4'($urandom), w[47:0]}; end
         3: begin ln = 2'd1; w = {4'hF, 8'h00, 4'h7, 5'd0, 3'($urandom % 2),
                                  ($urandom % 2) ? 8'h00 : 8'($urandom), w[31:0]}; end
         4: begin ln = 2'd2; w = {($urandom % 2) ? 4'h4 : 4'h5, 12'h000,
                                  ($urandom % 2) ? 16'h0 : 16'($urandom), 16'($urandom), w[15:0]}; end
         9: begin ln = 2'($urandom); end
         default: begin ln = 2'd3; w = enc64(8'($urandom % 9), w[31:0]); end
      endcase
      if ($urandom % 100 < 15) begin
         bits = 16 * (int'(ln) + 1);
         w = w ^ (64'd1 << (63 - int'($urandom % bits)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [1:0]  ln;
      logic [63:0] w;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) m_cp[i] = '0;
      for (int i = 0; i < 64; i++) m_ctl[i] = '0;
      for (int i = 0; i < 16; i++) m_core[i] = $urandom;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: every entry reads back as zero after reset
      for (int n = 0; n < 32; n++) begin
         run_instr(1'b1, 2'd0, rd_lo(5'(n), 4'(n % 16)), "R1");
         run_instr(1'b1, 2'd3, rd_hi(5'(n), 4'((n + 3) % 16)), "R1");
      end
      for (int c = 0; c < 16; c++) run_instr(1'b1, 2'd3, rd_ctl(4'(c), 4'(c)), "R1");

      // R7, R8, R2: load, splice the upper half, copy, read back
      m_core[3] = 32'hCAFE_0123; m_core[7] = 32'h89AB_CDEF;
      run_instr(1'b1, 2'd3, enc64(8'd1, {5'd5, 4'd3, 23'h7FFFFF}), "R7");
      run_instr(1'b1, 2'd3, enc64(8'd3, {5'd5, 4'd7, 23'd0}), "R8");
      run_instr(1'b1, 2'd0, {4'h1, 5'd9, 2'b00, 5'd5, 48'hFFFF_FFFF_FFFF}, "R2");
      run_instr(1'b1, 2'd0, rd_lo(5'd9, 4'd1), "R2");
      run_instr(1'b1, 2'd3, rd_hi(5'd9, 4'd2), "R8");
      check("R8", "core1_low_kept", 64'(m_core[1]), 64'h0000_0000_CAFE_0123);
      check("R8", "core2_high_spliced", 64'(m_core[2]), 64'h0000_0000_89AB_CDEF);

      // R9: control register round trip through the high index range of the field
      run_instr(1'b1, 2'd3, enc64(8'd5, {4'd15, 4'd7, 24'hFFFFFF}), "R9");
      run_instr(1'b1, 2'd3, rd_ctl(4'd15, 4'd0), "R9");

      // R6: exception only on a zero first immediate
      run_instr(1'b1, 2'd2, {4'h4, 12'h000, 16'h0000, 16'h1234, 16'hFFFF}, "R6");
      run_instr(1'b1, 2'd2, {4'h4, 12'h000, 16'h0001, 16'h0000, 16'h0000}, "R6");
      run_instr(1'b1, 2'd2, {4'h5, 12'h000, 16'h0000, 16'h0000, 16'h0000}, "R6");

      // R5 and R4
      run_instr(1'b1, 2'd1, {4'hF, 8'h00, 4'h7, 5'd0, 3'd1, 8'hA5, 32'hDEAD_BEEF}, "R5");
      run_instr(1'b1, 2'd1, {4'hF, 8'h00, 4'h7, 5'd0, 3'd0, 8'h00, 32'hFFFF_FFFF}, "R5");
      run_instr(1'b1, 2'd0, {16'h0000, 48'hFFFF_FFFF_FFFF}, "R4");

      // R10: malformed forms, then confirm nothing changed
      run_instr(1'b1, 2'd1, {4'hF, 8'h00, 4'h7, 5'd0, 3'd0, 8'h01, 32'h0}, "R10");
      run_instr(1'b1, 2'd0, {4'hF, 12'h000, 48'h0}, "R10");
      run_instr(1'b1, 2'd2, {4'h4, 12'h020, 16'h0000, 16'h0000, 16'h0}, "R10");
      run_instr(1'b1, 2'd0, {4'h2, 5'd5, 3'b100, 4'd3, 48'h0}, "R10");
      run_instr(1'b1, 2'd3, enc64(8'd8, {5'd5, 4'd3, 23'd0}), "R10");
      run_instr(1'b1, 2'd1, {4'hF, 8'h00, 4'h6, 5'd0, 3'd1, 8'h00, 32'h0}, "R12");
      run_instr(1'b1, 2'd3, rd_hi(5'd5, 4'd4), "R10");
      check("R10", "cp5_high_unchanged", 64'(m_core[4]), 64'h0000_0000_89AB_CDEF);

      // R13: a write presented without valid is ignored
      run_instr(1'b0, 2'd3, enc64(8'd1, {5'd5, 4'd0, 23'd0}), "R13");
      run_instr(1'b1, 2'd0, rd_lo(5'd5, 4'd6), "R13");
      check("R13", "cp5_low_unchanged", 64'(m_core[6]), 64'h0000_0000_CAFE_0123);

      // R11: back-to-back write then read lands on the next cycle
      run_instr(1'b1, 2'd0, {4'h2, 5'd20, 3'b000, 4'd2, 48'h0}, "R11");
      run_instr(1'b1, 2'd0, rd_lo(5'd20, 4'd8), "R11");

      for (int i = 0; i < 3000; i++) begin
         gen_random(ln, w);
         run_instr(($urandom % 16) != 0, ln, w, "");
      end

      @(negedge clk);
      in_valid = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule